// File: doc/BRIEF.md
# TLB lookup unit with protection checks

This block translates a virtual address into a physical address for 8 KB pages. It holds a small set-associative table of translation entries. Each entry is a pair of 32-bit words: a tag word carrying the virtual page number and an owner process ID, and a data word carrying the physical frame number and the permission flags. The page number selects one row of the table, and every way in that row is compared against the page number in parallel. The earliest matching way then goes through validity, ownership and write-permission checks.

A request is presented for one cycle. The result appears on the registered outputs in the next cycle: either a hit with a physical address, or a fault code. When the access fails, the block captures diagnostic state for the refill handler. A cause word records the page number, the access type and the requesting process ID. A slot word records the row a refill should target, but it is updated only when no usable entry was found. Entries are loaded through a synchronous write port, addressed by way and row. Loads can be issued in the same cycle as a lookup.

Top module: `tlb_lookup_unit`

## Requirements
- R1: While reset is held, and after it is released, every output register reads zero and every table entry reads as all-zero words. A lookup of page 0 with validity checking enabled then faults with code 0x8.
- R2: A load writes the tag and data words into the chosen way and row at the clock edge. A lookup in the same cycle as a load sees the contents from before the load.
- R3: The row is virtual address bits 16:13. A way matches when its tag bits 31:13 equal virtual address bits 31:13. When several ways match, the lowest-numbered way is used.
- R4: On a hit, one cycle after the request, rsp_hit is 1, rsp_vec is 0 and rsp_paddr is the data bits 31:13 followed by virtual address bits 12:0.
- R5: A miss is reported when no way matches, or when the used entry has data bit 3 (valid) clear while config bit 16 is set. A miss gives rsp_hit 0, rsp_vec 0x8 and rsp_paddr 0. It also loads the slot word with the row in bits 3:0, 0 in bits 5:4 and 0 in all other bits.
- R6: An entry with data bit 4 (global) clear gives rsp_vec 0xA when its tag bits 7:0 are neither 0xFF nor cur_pid. Global entries, entries with owner 0xFF and entries owned by cur_pid do not produce this fault.
- R7: A write access (req_write 1) to an entry with data bit 1 (writable) clear gives rsp_vec 0xB when config bit 19 is set. Reads, and writes made while config bit 19 is clear, do not produce this fault.
- R8: When several faults apply, the first one in this order is reported: miss or invalid (0x8), then owner mismatch (0xA), then write protection (0xB).
- R9: On any fault, the cause word is loaded with virtual address bits 31:13 in bits 31:13, zeros in bits 12:10, the access type in bits 9:8 (01 read, 10 write) and cur_pid in bits 7:0. A hit leaves the cause word unchanged. Faults 0xA and 0xB leave the slot word unchanged.
- R10: rsp_valid is req_valid delayed by one cycle. When req_valid is low, every other output holds its value. Config bits other than 16 and 19 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| cur_pid | input | 8 | Process ID of the requester |
| cfg_word | input | 32 | Check enables: bit 16 validity, bit 19 write protection |
| ld_en | input | 1 | Load an entry at this clock edge |
| ld_way | input | 2 | Way to load |
| ld_idx | input | 4 | Row to load |
| ld_hi | input | 32 | Tag word: page number 31:13, owner ID 7:0 |
| ld_lo | input | 32 | Data word: frame 31:13, global 4, valid 3, writable 1 |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_vec | output | 4 | Fault code (0 on a hit) |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| cause_q | output | 32 | Captured fault cause word |
| sel_q | output | 32 | Captured refill slot word |

## Verification
A load and a lookup can fall in the same cycle and target the same way and row. In that case the lookup must resolve against the old entry, and the new entry must be visible from the next cycle on. The bench provokes this on purpose with a directed load-plus-lookup on an empty slot, followed by a repeat lookup. It also provokes it at random, with loads and lookups drawn from a small page pool so that they collide often. Each result is judged against a bench model that evaluates the lookup before it applies the load. The same model orders overlapping faults by the stated priority.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // fault codes reported on rsp_vec
  localparam logic [3:0] VEC_NONE = 4'h0;
  localparam logic [3:0] VEC_MISS = 4'h8;
  localparam logic [3:0] VEC_PID  = 4'hA;
  localparam logic [3:0] VEC_WP   = 4'hB;

  // access type codes in the cause word
  localparam logic [1:0] ACC_RD = 2'b01;
  localparam logic [1:0] ACC_WR = 2'b10;
  localparam int CAUSE_ACC_LSB = 8;

  // data word flag positions
  localparam int LO_GLOBAL = 4;
  localparam int LO_VALID  = 3;
  localparam int LO_WRITE  = 1;

  // config word check enables
  localparam int CFG_CHK_VALID = 16;
  localparam int CFG_CHK_WRITE = 19;

  typedef enum logic [1:0] {
    RES_HIT  = 2'd0,
    RES_MISS = 2'd1,
    RES_PID  = 2'd2,
    RES_WP   = 2'd3
  } lookup_res_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WORD_W-1:0]           wr_hi,
  input  logic [WORD_W-1:0]           wr_lo,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [WAYS-1:0][WORD_W-1:0] rd_hi,
  output logic [WAYS-1:0][WORD_W-1:0] rd_lo
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0][WORD_W-1:0] hi_mem;
    logic [SETS-1:0][WORD_W-1:0] lo_mem;
    logic                        way_we;

    always_comb begin
      way_we = wr_en && (wr_way == WAY_W'(w));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_mem <= '0;
        lo_mem <= '0;
      end else if (way_we) begin
        hi_mem[wr_idx] <= wr_hi;
        lo_mem[wr_idx] <= wr_lo;
      end
    end

    always_comb begin
      rd_hi[w] = hi_mem[rd_idx];
      rd_lo[w] = lo_mem[rd_idx];
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int WAYS       = 4,
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int PID_W      = 8,
  localparam int VPN_W     = WORD_W - PAGE_SHIFT
) (
  input  logic [WAYS-1:0][WORD_W-1:0] way_hi,
  input  logic [WAYS-1:0][WORD_W-1:0] way_lo,
  input  logic [VPN_W-1:0]            vpn,
  output logic                        found,
  output logic [PID_W-1:0]            ent_pid,
  output logic [WORD_W-1:0]           ent_lo
);
  logic [WAYS-1:0] way_eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_eq[w] = (way_hi[w][WORD_W-1:PAGE_SHIFT] == vpn);
  end

  // lowest matching way wins: scan from the top so the lowest lands last
  always_comb begin
    found   = 1'b0;
    ent_pid = '0;
    ent_lo  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_eq[w]) begin
        found   = 1'b1;
        ent_pid = way_hi[w][PID_W-1:0];
        ent_lo  = way_lo[w];
      end
    end
  end

  logic unused_hi_bits;
  always_comb begin
    unused_hi_bits = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      unused_hi_bits = unused_hi_bits ^ (^way_hi[w][PAGE_SHIFT-1:PID_W]);
    end
  end
endmodule

// File: rtl/tlb_check.sv
module tlb_check
  import tlb_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int PID_W      = 8,
  parameter int IDX_W      = 4,
  localparam int VPN_W     = WORD_W - PAGE_SHIFT
) (
  input  logic              found,
  input  logic [PID_W-1:0]  ent_pid,
  input  logic [WORD_W-1:0] ent_lo,
  input  logic [WORD_W-1:0] vaddr,
  input  logic              is_write,
  input  logic [PID_W-1:0]  cur_pid,
  input  logic              chk_valid,
  input  logic              chk_write,
  output logic              hit,
  output logic [3:0]        vec,
  output logic [WORD_W-1:0] paddr,
  output logic              upd_cause,
  output logic              upd_sel,
  output logic [WORD_W-1:0] cause_val,
  output logic [WORD_W-1:0] sel_val
);
  localparam logic [PID_W-1:0] PID_ANY = '1;

  lookup_res_e res;
  logic        bad_valid;
  logic        bad_owner;
  logic        bad_write;
  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] row;

  assign vpn = vaddr[WORD_W-1:PAGE_SHIFT];
  assign row = vaddr[PAGE_SHIFT+IDX_W-1:PAGE_SHIFT];

  always_comb begin
    bad_valid = chk_valid && !ent_lo[LO_VALID];
    bad_owner = !ent_lo[LO_GLOBAL] && (ent_pid != PID_ANY) && (ent_pid != cur_pid);
    bad_write = is_write && chk_write && !ent_lo[LO_WRITE];
  end

  // fault priority: miss/invalid, owner, write protection
  always_comb begin
    if (!found || bad_valid) res = RES_MISS;
    else if (bad_owner)      res = RES_PID;
    else if (bad_write)      res = RES_WP;
    else                     res = RES_HIT;
  end

  always_comb begin
    hit       = (res == RES_HIT);
    upd_cause = !hit;
    upd_sel   = (res == RES_MISS);
    paddr     = '0;
    case (res)
      RES_MISS: vec = VEC_MISS;
      RES_PID:  vec = VEC_PID;
      RES_WP:   vec = VEC_WP;
      default:  vec = VEC_NONE;
    endcase
    if (hit) begin
      paddr = {ent_lo[WORD_W-1:PAGE_SHIFT], vaddr[PAGE_SHIFT-1:0]};
    end
  end

  always_comb begin
    cause_val = '0;
    cause_val[WORD_W-1:PAGE_SHIFT] = vpn;
    cause_val[CAUSE_ACC_LSB +: 2]  = is_write ? ACC_WR : ACC_RD;
    cause_val[PID_W-1:0]           = cur_pid;
    sel_val = '0;
    sel_val[IDX_W-1:0] = row;
  end

  logic unused_lo_bits;
  assign unused_lo_bits = ^{ent_lo[PAGE_SHIFT-1:LO_GLOBAL+1], ent_lo[LO_VALID-1], ent_lo[0]};
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
  import tlb_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int PID_W      = 8,
  localparam int IDX_W     = $clog2(SETS),
  localparam int WAY_W     = $clog2(WAYS),
  localparam int VPN_W     = WORD_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [WORD_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic [PID_W-1:0]  cur_pid,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              ld_en,
  input  logic [WAY_W-1:0]  ld_way,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_hi,
  input  logic [WORD_W-1:0] ld_lo,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [3:0]        rsp_vec,
  output logic [WORD_W-1:0] rsp_paddr,
  output logic [WORD_W-1:0] cause_q,
  output logic [WORD_W-1:0] sel_q
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [WAYS-1:0][WORD_W-1:0] row_hi;
  logic [WAYS-1:0][WORD_W-1:0] row_lo;
  logic                        m_found;
  logic [PID_W-1:0]            m_pid;
  logic [WORD_W-1:0]           m_lo;
  logic                        c_hit;
  logic [3:0]                  c_vec;
  logic [WORD_W-1:0]           c_paddr;
  logic                        c_upd_cause;
  logic                        c_upd_sel;
  logic [WORD_W-1:0]           c_cause;
  logic [WORD_W-1:0]           c_sel;

  tlb_store #(.WAYS(WAYS), .SETS(SETS), .WORD_W(WORD_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (ld_en),
    .wr_way (ld_way),
    .wr_idx (ld_idx),
    .wr_hi  (ld_hi),
    .wr_lo  (ld_lo),
    .rd_idx (req_vaddr[PAGE_SHIFT+IDX_W-1:PAGE_SHIFT]),
    .rd_hi  (row_hi),
    .rd_lo  (row_lo)
  );

  tlb_match #(.WAYS(WAYS), .WORD_W(WORD_W), .PAGE_SHIFT(PAGE_SHIFT), .PID_W(PID_W)) u_match (
    .way_hi  (row_hi),
    .way_lo  (row_lo),
    .vpn     (req_vaddr[WORD_W-1:PAGE_SHIFT]),
    .found   (m_found),
    .ent_pid (m_pid),
    .ent_lo  (m_lo)
  );

  tlb_check #(.WORD_W(WORD_W), .PAGE_SHIFT(PAGE_SHIFT), .PID_W(PID_W), .IDX_W(IDX_W)) u_check (
    .found     (m_found),
    .ent_pid   (m_pid),
    .ent_lo    (m_lo),
    .vaddr     (req_vaddr),
    .is_write  (req_write),
    .cur_pid   (cur_pid),
    .chk_valid (cfg_word[CFG_CHK_VALID]),
    .chk_write (cfg_word[CFG_CHK_WRITE]),
    .hit       (c_hit),
    .vec       (c_vec),
    .paddr     (c_paddr),
    .upd_cause (c_upd_cause),
    .upd_sel   (c_upd_sel),
    .cause_val (c_cause),
    .sel_val   (c_sel)
  );

  // next state
  logic              nxt_valid;
  logic              nxt_hit;
  logic [3:0]        nxt_vec;
  logic [WORD_W-1:0] nxt_paddr;
  logic [WORD_W-1:0] nxt_cause;
  logic [WORD_W-1:0] nxt_sel;
  logic              rsp_en;
  logic              cause_en;
  logic              sel_en;

  always_comb begin
    nxt_valid = req_valid;
    rsp_en    = req_valid;
    cause_en  = req_valid && c_upd_cause;
    sel_en    = req_valid && c_upd_sel;
    nxt_hit   = c_hit;
    nxt_vec   = c_vec;
    nxt_paddr = c_paddr;
    nxt_cause = c_cause;
    nxt_sel   = c_sel;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_vec   <= '0;
      rsp_paddr <= '0;
      cause_q   <= '0;
      sel_q     <= '0;
    end else begin
      rsp_valid <= nxt_valid;
      if (rsp_en) begin
        rsp_hit   <= nxt_hit;
        rsp_vec   <= nxt_vec;
        rsp_paddr <= nxt_paddr;
      end
      if (cause_en) cause_q <= nxt_cause;
      if (sel_en)   sel_q   <= nxt_sel;
    end
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_word[WORD_W-1:CFG_CHK_WRITE+1],
                             cfg_word[CFG_CHK_WRITE-1:CFG_CHK_VALID+1],
                             cfg_word[CFG_CHK_VALID-1:0]};
endmodule

// File: rtl/tlb_lookup_sva.sv
module tlb_lookup_sva #(
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int PID_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [WORD_W-1:0] req_vaddr,
  input logic [PID_W-1:0]  cur_pid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [3:0]        rsp_vec,
  input logic [WORD_W-1:0] rsp_paddr,
  input logic [WORD_W-1:0] cause_q,
  input logic [WORD_W-1:0] sel_q
);
  // R10: response strobe follows the request by one cycle
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R10: result fields hold without a request
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_hit) && $stable(rsp_vec) && $stable(rsp_paddr)
                    && $stable(cause_q) && $stable(sel_q)));
  // R4: a hit carries no fault code and keeps the page offset
  p_hit_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_vec == 4'h0));
  p_hit_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_paddr[PAGE_SHIFT-1:0] == $past(req_vaddr[PAGE_SHIFT-1:0])));
  // R8: a fault carries one of the three codes and no address
  p_fault_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> ((rsp_vec == 4'h8 || rsp_vec == 4'hA || rsp_vec == 4'hB)
                                 && rsp_paddr == '0));
  // R5: slot word only moves on a miss
  p_sel_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> (rsp_valid && rsp_vec == 4'h8));
  // R9: cause word untouched by hits, captures requester ID on faults
  p_cause_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $stable(cause_q));
  p_cause_pid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (cause_q[PID_W-1:0] == $past(cur_pid)));
endmodule

bind tlb_lookup_unit tlb_lookup_sva #(
  .WORD_W(WORD_W), .PAGE_SHIFT(PAGE_SHIFT), .PID_W(PID_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .cur_pid   (cur_pid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_vec   (rsp_vec),
  .rsp_paddr (rsp_paddr),
  .cause_q   (cause_q),
  .sel_q     (sel_q)
);

// File: tb/tb_tlb_lookup_unit.sv
module tb_tlb_lookup_unit;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic [7:0]  cur_pid;
  logic [31:0] cfg_word;
  logic        ld_en;
  logic [1:0]  ld_way;
  logic [3:0]  ld_idx;
  logic [31:0] ld_hi;
  logic [31:0] ld_lo;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [3:0]  rsp_vec;
  logic [31:0] rsp_paddr;
  logic [31:0] cause_q;
  logic [31:0] sel_q;

  tlb_lookup_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .cur_pid(cur_pid), .cfg_word(cfg_word),
    .ld_en(ld_en), .ld_way(ld_way), .ld_idx(ld_idx), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_vec(rsp_vec),
    .rsp_paddr(rsp_paddr), .cause_q(cause_q), .sel_q(sel_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model of the table and captured words
  logic [31:0] m_hi [4][16];
  logic [31:0] m_lo [4][16];
  logic        e_hit;
  logic [3:0]  e_vec;
  logic [31:0] e_paddr;
  logic [31:0] e_cause;
  logic [31:0] e_sel;

  localparam logic [31:0] CFG_BOTH = 32'h0009_0000;
  localparam logic [31:0] CFG_VAL  = 32'h0001_0000;
  localparam logic [31:0] CFG_WR   = 32'h0008_0000;
  localparam logic [31:0] CFG_NONE = 32'h0000_0000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkhi(input logic [18:0] vpn, input logic [7:0] pid);
    return {vpn, 5'b0, pid};
  endfunction

  function automatic logic [31:0] mklo(input logic [18:0] pfn, input bit g, input bit v, input bit w);
    return {pfn, 8'b0, g, v, 1'b0, w, 1'b0};
  endfunction

  function automatic logic [31:0] mkva(input logic [18:0] vpn, input logic [12:0] off);
    return {vpn, off};
  endfunction

  task automatic predict(input logic [31:0] va, input bit wr, input logic [7:0] pid,
                         input logic [31:0] cfg);
    int way = -1;
    logic [3:0] row = va[16:13];
    for (int w = 0; w < 4; w++)
      if (way < 0 && m_hi[w][row][31:13] == va[31:13]) way = w;
    e_paddr = 32'h0;
    e_hit = 1'b0;
    if (way < 0 || (cfg[16] && !m_lo[way][row][3])) e_vec = 4'h8;
    else if (!m_lo[way][row][4] && m_hi[way][row][7:0] != 8'hFF && m_hi[way][row][7:0] != pid)
      e_vec = 4'hA;
    else if (wr && cfg[19] && !m_lo[way][row][1]) e_vec = 4'hB;
    else begin
      e_vec = 4'h0;
      e_hit = 1'b1;
      e_paddr = {m_lo[way][row][31:13], va[12:0]};
    end
    if (!e_hit) e_cause = {va[31:13], 3'b000, wr ? 2'b10 : 2'b01, pid};
    if (e_vec == 4'h8) e_sel = {28'h0, row};
  endtask

  // one cycle: drive at the falling edge, check at the next falling edge
  task automatic cyc(input bit rq, input logic [31:0] va, input bit wr, input logic [7:0] pid,
                     input logic [31:0] cfg, input bit ld, input logic [1:0] lw,
                     input logic [3:0] li, input logic [31:0] lh, input logic [31:0] ll,
                     input string tag);
    string t;
    req_valid = rq; req_vaddr = va; req_write = wr; cur_pid = pid; cfg_word = cfg;
    ld_en = ld; ld_way = lw; ld_idx = li; ld_hi = lh; ld_lo = ll;
    if (rq) predict(va, wr, pid, cfg);
    @(posedge clk);
    if (ld) begin
      m_hi[lw][li] = lh;
      m_lo[lw][li] = ll;
    end
    @(negedge clk);
    t = tag;
    if (t == "") t = !rq ? "R10" : e_hit ? "R4" : (e_vec == 4'h8) ? "R5" :
                     (e_vec == 4'hA) ? "R6" : "R7";
    chk({t, " rsp_valid"}, {31'b0, rsp_valid}, {31'b0, rq});
    chk({t, " rsp_hit"}, {31'b0, rsp_hit}, {31'b0, e_hit});
    chk({t, " rsp_vec"}, {28'b0, rsp_vec}, {28'b0, e_vec});
    chk({t, " rsp_paddr"}, rsp_paddr, e_paddr);
    chk({t, " R9 cause"}, cause_q, e_cause);
    chk({t, " R5 sel"}, sel_q, e_sel);
    req_valid = 1'b0;
    ld_en = 1'b0;
  endtask

  task automatic load(input logic [1:0] lw, input logic [3:0] li,
                      input logic [31:0] lh, input logic [31:0] ll);
    cyc(0, 32'h0, 0, 8'h11, CFG_BOTH, 1, lw, li, lh, ll, "R10");
  endtask

  task automatic look(input logic [31:0] va, input bit wr, input logic [7:0] pid,
                      input logic [31:0] cfg, input string tag);
    cyc(1, va, wr, pid, cfg, 0, 2'd0, 4'd0, 32'h0, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240613);
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 16; i++) begin
        m_hi[w][i] = 32'h0;
        m_lo[w][i] = 32'h0;
      end
    e_hit = 0; e_vec = 0; e_paddr = 0; e_cause = 0; e_sel = 0;
    rst_n = 1'b0;
    req_valid = 0; req_vaddr = 0; req_write = 0; cur_pid = 8'h11; cfg_word = 0;
    ld_en = 0; ld_way = 0; ld_idx = 0; ld_hi = 0; ld_lo = 0;
    repeat (3) @(negedge clk);
    // R1: registers zero during reset
    chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R1 reset rsp_hit", {31'b0, rsp_hit}, 32'h0);
    chk("R1 reset rsp_vec", {28'b0, rsp_vec}, 32'h0);
    chk("R1 reset rsp_paddr", rsp_paddr, 32'h0);
    chk("R1 reset cause", cause_q, 32'h0);
    chk("R1 reset sel", sel_q, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: cleared table gives a miss on page 0
    look(mkva(19'h0, 13'h5), 0, 8'h11, CFG_BOTH, "R1");
    chk("R1 cause literal", cause_q, 32'h0000_0111);

    // R2: load and lookup of the same slot in one cycle
    cyc(1, mkva(19'h25, 13'h0ABC), 0, 8'h11, CFG_BOTH, 1, 2'd2, 4'd5,
        mkhi(19'h25, 8'h11), mklo(19'h1234, 0, 1, 1), "R2");
    chk("R2 old entry seen", {28'b0, rsp_vec}, 32'h8);
    look(mkva(19'h25, 13'h0ABC), 0, 8'h11, CFG_BOTH, "R2");
    chk("R2 new entry paddr", rsp_paddr, {19'h1234, 13'h0ABC});

    // R3: two ways match, lowest wins
    load(2'd3, 4'd7, mkhi(19'h17, 8'h11), mklo(19'h333, 1, 1, 1));
    load(2'd1, 4'd7, mkhi(19'h17, 8'h11), mklo(19'h111, 1, 1, 1));
    look(mkva(19'h17, 13'h1F0F), 1, 8'h11, CFG_BOTH, "R3");
    chk("R3 lowest way paddr", rsp_paddr, {19'h111, 13'h1F0F});

    // R5: invalid entry with and without the validity check
    load(2'd0, 4'd9, mkhi(19'h09, 8'h11), mklo(19'h55, 1, 0, 1));
    look(mkva(19'h09, 13'h0001), 0, 8'h11, CFG_BOTH, "R5");
    chk("R5 sel literal", sel_q, 32'h0000_0009);
    look(mkva(19'h09, 13'h0001), 0, 8'h11, CFG_WR, "R5");
    look(mkva(19'h79, 13'h0001), 0, 8'h11, CFG_NONE, "R5");

    // R6: ownership
    load(2'd0, 4'd10, mkhi(19'h0A, 8'h33), mklo(19'h66, 0, 1, 1));
    look(mkva(19'h0A, 13'h0010), 0, 8'h11, CFG_BOTH, "R6");
    chk("R6 vec literal", {28'b0, rsp_vec}, 32'hA);
    look(mkva(19'h0A, 13'h0010), 0, 8'h33, CFG_BOTH, "R6");
    load(2'd1, 4'd11, mkhi(19'h0B, 8'hFF), mklo(19'h77, 0, 1, 1));
    look(mkva(19'h0B, 13'h0020), 0, 8'h42, CFG_BOTH, "R6");
    load(2'd2, 4'd12, mkhi(19'h0C, 8'h99), mklo(19'h88, 1, 1, 1));
    look(mkva(19'h0C, 13'h0030), 0, 8'h42, CFG_BOTH, "R6");

    // R7: write protection
    load(2'd0, 4'd13, mkhi(19'h0D, 8'h11), mklo(19'h99, 0, 1, 0));
    look(mkva(19'h0D, 13'h0040), 1, 8'h11, CFG_BOTH, "R7");
    chk("R7 vec literal", {28'b0, rsp_vec}, 32'hB);
    chk("R7 cause write type", {30'b0, cause_q[9:8]}, 32'h2);
    look(mkva(19'h0D, 13'h0040), 0, 8'h11, CFG_BOTH, "R7");
    look(mkva(19'h0D, 13'h0040), 1, 8'h11, CFG_VAL, "R7");

    // R8: overlapping faults
    load(2'd0, 4'd14, mkhi(19'h0E, 8'h33), mklo(19'hAA, 0, 0, 0));
    look(mkva(19'h0E, 13'h0050), 1, 8'h11, CFG_BOTH, "R8");
    chk("R8 invalid first", {28'b0, rsp_vec}, 32'h8);
    look(mkva(19'h0E, 13'h0050), 1, 8'h11, CFG_WR, "R8");
    chk("R8 owner before write", {28'b0, rsp_vec}, 32'hA);

    // R10: idle cycles and ignored config bits
    cyc(0, 32'hFFFF_FFFF, 1, 8'h00, 32'hFFFF_FFFF, 0, 2'd0, 4'd0, 32'h0, 32'h0, "R10");
    look(mkva(19'h25, 13'h0123), 0, 8'h11, 32'hFFF6_FFFF | CFG_NONE, "R10");

    // constrained random traffic over a small page pool
    for (int n = 0; n < 1500; n++) begin
      logic [18:0] vpn;
      logic [18:0] lvpn;
      logic [7:0]  pid;
      logic [7:0]  opid;
      logic [31:0] cfg;
      bit          rq;
      bit          ld;
      vpn  = {13'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
      lvpn = ($urandom_range(0, 3) == 0) ? vpn :
             {13'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
      pid  = ($urandom_range(0, 1) == 0) ? 8'h11 : 8'h22;
      case ($urandom_range(0, 3))
        0: opid = 8'h11;
        1: opid = 8'h22;
        2: opid = 8'hFF;
        default: opid = 8'($urandom);
      endcase
      cfg = $urandom;
      rq = ($urandom_range(0, 4) != 0);
      ld = ($urandom_range(0, 2) == 0);
      cyc(rq, {vpn, 13'($urandom)}, 1'($urandom), pid, cfg, ld,
          2'($urandom), lvpn[3:0], mkhi(lvpn, opid),
          {19'($urandom), 8'($urandom), 5'($urandom)}, "");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule